// File: doc/BRIEF.md
# Effective Address Generator with Pointer Update

This block turns an operand addressing request into a 32-bit memory address. Each request carries a mode code, a base pointer, an index value, an instruction displacement and the program counter. The block forms the address from these in one combinational step and registers the result. For the four auto-update modes it also returns the new pointer value so that the register file can write it back.

A request is accepted on a cycle where `valid_i` is high. The address and the writeback value appear on the outputs one clock later, and they stay there until the next accepted request. Mode codes 0 to 10 are defined. Codes 11 to 15 are reserved.

Top module: `ea_gen`

## Requirements
- R1: `valid_o` is `valid_i` delayed by one clock. While `rst_ni` is low, `valid_o`, `addr_o`, `wb_valid_o` and `wb_data_o` are all zero.
- R2: A cycle with `valid_i` low leaves `addr_o`, `wb_valid_o` and `wb_data_o` unchanged. `valid_o` is low in the next cycle.
- R3: Mode 0 (plain indirect) gives `addr_o` = base and no writeback.
- R4: Mode 1 (use then increment) and mode 4 (use then decrement) give `addr_o` = base. They assert `wb_valid_o` with `wb_data_o` = base plus or minus the step. The step for `size_i` codes 0, 1, 2 and 3 is 1, 2, 4 and 4.
- R5: Mode 3 (increment then use) and mode 2 (decrement then use) give `addr_o` = `wb_data_o` = base plus or minus the step, with `wb_valid_o` high.
- R6: Mode 5 gives base + sign-extended `disp_i[15:0]`, with no writeback.
- R7: Mode 6 gives base + scaled index + displacement. The index is sign-extended `index_i[15:0]` when `idx_long_i` is 0 and all of `index_i` when it is 1. It is shifted left by `scale_i` (factor 1, 2, 4 or 8). The displacement is sign-extended `disp_i[7:0]` for `disp_sz_i` = 0, sign-extended `disp_i[15:0]` for 1, and all of `disp_i` for 2 or 3.
- R8: Mode 7 gives sign-extended `disp_i[15:0]` and mode 8 gives `disp_i`. Neither uses a register or writes back.
- R9: Modes 9 and 10 behave like modes 5 and 6, with `pc_i` in place of the base pointer and no writeback.
- R10: All address and pointer arithmetic wraps modulo 2^32.
- R11: Reserved modes 11 to 15 give `addr_o` = base and no writeback.
- R12: `wb_data_o` is zero whenever `wb_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 4 | Addressing mode code |
| size_i | input | 2 | Operand size code for the pointer step |
| base_i | input | 32 | Base pointer register |
| index_i | input | 32 | Index register |
| idx_long_i | input | 1 | Selects the full index (1) or the sign-extended low half (0) |
| scale_i | input | 2 | Index shift amount (0 to 3) |
| disp_i | input | 32 | Displacement or absolute address field |
| disp_sz_i | input | 2 | Displacement width code for the indexed modes |
| pc_i | input | 32 | Program counter |
| valid_o | output | 1 | Result strobe |
| addr_o | output | 32 | Effective address |
| wb_valid_o | output | 1 | Pointer writeback request |
| wb_data_o | output | 32 | Updated pointer value |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit short field and an 8-bit byte field. With these widths, directed values near 0 and 0xFFFF_FFFF reach the wrap-around cases. Values with bit 7 or bit 15 set exercise each sign-extension path. Random requests cover all sixteen mode codes, every size, scale and displacement-width code, and both index widths. Cycles with `valid_i` low are placed between requests to test the hold behaviour.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    EA_IND     = 4'd0,
    EA_POSTINC = 4'd1,
    EA_PREDEC  = 4'd2,
    EA_PREINC  = 4'd3,
    EA_POSTDEC = 4'd4,
    EA_DISP    = 4'd5,
    EA_IDX     = 4'd6,
    EA_ABS_S   = 4'd7,
    EA_ABS_L   = 4'd8,
    EA_PC_DISP = 4'd9,
    EA_PC_IDX  = 4'd10
  } ea_mode_e;
endpackage

// File: rtl/ea_sext.sv
module ea_sext #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int PAD_W = OUT_W - IN_W;
  assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
endmodule

// File: rtl/ea_disp.sv
module ea_disp #(
  parameter int AW      = 32,
  parameter int SHORT_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic [AW-1:0] disp_i,
  input  logic [1:0]    dsz_i,
  output logic [AW-1:0] d_short_o,
  output logic [AW-1:0] d_sel_o
);
  logic [AW-1:0] d_byte;

  ea_sext #(.IN_W(BYTE_W),  .OUT_W(AW)) u_sx_b (.val_i(disp_i[BYTE_W-1:0]),  .val_o(d_byte));
  ea_sext #(.IN_W(SHORT_W), .OUT_W(AW)) u_sx_s (.val_i(disp_i[SHORT_W-1:0]), .val_o(d_short_o));

  always_comb begin
    unique case (dsz_i)
      2'd0:    d_sel_o = d_byte;
      2'd1:    d_sel_o = d_short_o;
      default: d_sel_o = disp_i;
    endcase
  end
endmodule

// File: rtl/ea_index.sv
module ea_index #(
  parameter int AW      = 32,
  parameter int SHORT_W = 16
) (
  input  logic [AW-1:0] index_i,
  input  logic          long_i,
  input  logic [1:0]    scale_i,
  output logic [AW-1:0] scaled_o
);
  logic [AW-1:0] idx_short;
  logic [AW-1:0] idx_sel;

  ea_sext #(.IN_W(SHORT_W), .OUT_W(AW)) u_sx (.val_i(index_i[SHORT_W-1:0]), .val_o(idx_short));

  assign idx_sel  = long_i ? index_i : idx_short;
  assign scaled_o = idx_sel << scale_i;
endmodule

// File: rtl/ea_step.sv
module ea_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] inc_o,
  output logic [AW-1:0] dec_o
);
  logic [AW-1:0] step;

  always_comb begin
    unique case (size_i)
      2'd0:    step = AW'(1);
      2'd1:    step = AW'(2);
      default: step = AW'(4);
    endcase
  end

  assign inc_o = base_i + step;
  assign dec_o = base_i - step;

  always_comb begin
    p_step_onehot_r4: assert ($onehot(step) && step <= AW'(4));
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW      = 32,
  parameter int SHORT_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic          idx_long_i,
  input  logic [1:0]    scale_i,
  input  logic [AW-1:0] disp_i,
  input  logic [1:0]    disp_sz_i,
  input  logic [AW-1:0] pc_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic          wb_valid_o,
  output logic [AW-1:0] wb_data_o
);
  logic [AW-1:0] d_short, d_sel, idx_sc, p_inc, p_dec;
  logic [AW-1:0] addr_n, wb_n;
  logic          wbv_n;

  ea_disp  #(.AW(AW), .SHORT_W(SHORT_W), .BYTE_W(BYTE_W)) u_disp (
    .disp_i(disp_i), .dsz_i(disp_sz_i), .d_short_o(d_short), .d_sel_o(d_sel));
  ea_index #(.AW(AW), .SHORT_W(SHORT_W)) u_index (
    .index_i(index_i), .long_i(idx_long_i), .scale_i(scale_i), .scaled_o(idx_sc));
  ea_step  #(.AW(AW)) u_step (
    .base_i(base_i), .size_i(size_i), .inc_o(p_inc), .dec_o(p_dec));

  always_comb begin
    addr_n = base_i;
    wb_n   = '0;
    wbv_n  = 1'b0;
    case (mode_i)
      EA_POSTINC: begin wbv_n = 1'b1; wb_n = p_inc; end
      EA_PREDEC:  begin wbv_n = 1'b1; wb_n = p_dec; addr_n = p_dec; end
      EA_PREINC:  begin wbv_n = 1'b1; wb_n = p_inc; addr_n = p_inc; end
      EA_POSTDEC: begin wbv_n = 1'b1; wb_n = p_dec; end
      EA_DISP:    addr_n = base_i + d_short;
      EA_IDX:     addr_n = base_i + idx_sc + d_sel;
      EA_ABS_S:   addr_n = d_short;
      EA_ABS_L:   addr_n = disp_i;
      EA_PC_DISP: addr_n = pc_i + d_short;
      EA_PC_IDX:  addr_n = pc_i + idx_sc + d_sel;
      default:    ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      addr_o     <= '0;
      wb_valid_o <= 1'b0;
      wb_data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        addr_o     <= addr_n;
        wb_valid_o <= wbv_n;
        wb_data_o  <= wb_n;
      end
    end
  end

  p_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(addr_o) && $stable(wb_data_o) && $stable(wb_valid_o)));
  p_ind_nowb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == EA_IND) |=> (!wb_valid_o && addr_o == $past(base_i)));
  p_postinc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == EA_POSTINC) |=>
      (wb_valid_o && $onehot(wb_data_o - addr_o) && (wb_data_o - addr_o) <= AW'(4)));
  p_pre_same_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (mode_i == EA_PREDEC || mode_i == EA_PREINC)) |=>
      (wb_valid_o && wb_data_o == addr_o));
  p_abs_nowb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == EA_ABS_L) |=> (!wb_valid_o && addr_o == $past(disp_i)));
  p_wb_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_valid_o |-> wb_data_o == '0);
endmodule

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] base_i = '0, index_i = '0, disp_i = '0, pc_i = '0;
  logic        idx_long_i = 1'b0;
  logic [1:0]  scale_i = '0, disp_sz_i = '0;
  logic        valid_o, wb_valid_o;
  logic [31:0] addr_o, wb_data_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ea_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i), .size_i(size_i),
    .base_i(base_i), .index_i(index_i), .idx_long_i(idx_long_i), .scale_i(scale_i),
    .disp_i(disp_i), .disp_sz_i(disp_sz_i), .pc_i(pc_i),
    .valid_o(valid_o), .addr_o(addr_o), .wb_valid_o(wb_valid_o), .wb_data_o(wb_data_o));

  function automatic logic [31:0] sx16(input logic [31:0] v);
    return {{16{v[15]}}, v[15:0]};
  endfunction

  function automatic void model(input logic [3:0] m, input logic [1:0] sz,
      input logic [31:0] b, input logic [31:0] ix, input logic il, input logic [1:0] sc,
      input logic [31:0] d, input logic [1:0] dsz, input logic [31:0] pc,
      output logic [31:0] ea, output logic wv, output logic [31:0] wd);
    logic [31:0] st, xi, dd;
    st = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    xi = (il ? ix : sx16(ix)) << sc;
    dd = (dsz == 2'd0) ? {{24{d[7]}}, d[7:0]} : (dsz == 2'd1) ? sx16(d) : d;
    ea = b; wv = 1'b0; wd = '0;
    case (m)
      4'd1:  begin wv = 1'b1; wd = b + st; end
      4'd2:  begin wv = 1'b1; wd = b - st; ea = wd; end
      4'd3:  begin wv = 1'b1; wd = b + st; ea = wd; end
      4'd4:  begin wv = 1'b1; wd = b - st; end
      4'd5:  ea = b + sx16(d);
      4'd6:  ea = b + xi + dd;
      4'd7:  ea = sx16(d);
      4'd8:  ea = d;
      4'd9:  ea = pc + sx16(d);
      4'd10: ea = pc + xi + dd;
      default: ;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0: return "R3";
      4'd1, 4'd4: return "R4";
      4'd2, 4'd3: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7, 4'd8: return "R8";
      4'd9, 4'd10: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input logic [3:0] m, input logic [1:0] sz, input logic [31:0] b,
      input logic [31:0] ix, input logic il, input logic [1:0] sc, input logic [31:0] d,
      input logic [1:0] dsz, input logic [31:0] pc, input string extra);
    logic [31:0] ea, wd;
    logic wv;
    model(m, sz, b, ix, il, sc, d, dsz, pc, ea, wv, wd);
    valid_i = 1'b1; mode_i = m; size_i = sz; base_i = b; index_i = ix; idx_long_i = il;
    scale_i = sc; disp_i = d; disp_sz_i = dsz; pc_i = pc;
    @(negedge clk_i);
    check(valid_o === 1'b1, "R1 valid", {31'd0, valid_o}, 32'd1);
    check(addr_o === ea, {tag_of(m), extra, " addr"}, addr_o, ea);
    check(wb_valid_o === wv, {tag_of(m), " wb_valid"}, {31'd0, wb_valid_o}, {31'd0, wv});
    check(wb_data_o === wd, {tag_of(m), " wb_data R12"}, wb_data_o, wd);
  endtask

  task automatic idle_cycle();
    logic [31:0] a0, w0;
    logic v0;
    a0 = addr_o; w0 = wb_data_o; v0 = wb_valid_o;
    valid_i = 1'b0; mode_i = 4'($urandom_range(0, 15)); base_i = $urandom; disp_i = $urandom;
    pc_i = $urandom; index_i = $urandom; size_i = 2'($urandom);
    @(negedge clk_i);
    check(valid_o === 1'b0, "R2 valid low", {31'd0, valid_o}, 32'd0);
    check(addr_o === a0, "R2 addr hold", addr_o, a0);
    check(wb_data_o === w0 && wb_valid_o === v0, "R2 wb hold", wb_data_o, w0);
  endtask

  initial begin
    repeat (400000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk_i);
    check(valid_o === 1'b0 && wb_valid_o === 1'b0, "R1 reset flags", {30'd0, valid_o, wb_valid_o}, 32'd0);
    check(addr_o === 32'd0 && wb_data_o === 32'd0, "R1 reset data", addr_o | wb_data_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed corners
    run(4'd0, 2'd0, 32'h1000_0000, 0, 0, 0, 32'h55, 0, 0, " ind");
    run(4'd1, 2'd2, 32'hFFFF_FFFE, 0, 0, 0, 0, 0, 0, " R10 postinc wrap");
    run(4'd2, 2'd0, 32'h0, 0, 0, 0, 0, 0, 0, " R10 predec wrap");
    run(4'd3, 2'd1, 32'h0000_0100, 0, 0, 0, 0, 0, 0, " preinc word");
    run(4'd4, 2'd3, 32'h0000_0002, 0, 0, 0, 0, 0, 0, " postdec size3 wrap");
    idle_cycle();
    run(4'd5, 2'd0, 32'h0000_0000, 0, 0, 0, 32'h1234_8000, 0, 0, " neg disp16");
    run(4'd6, 2'd0, 32'h0001_0000, 32'h1234_FFFF, 0, 2'd3, 32'h0000_0080, 2'd0, 0, " short index x8 disp8");
    run(4'd6, 2'd0, 32'h0001_0000, 32'h0000_0010, 1, 2'd2, 32'h8000_0000, 2'd2, 0, " long index disp32");
    run(4'd7, 2'd0, 32'hDEAD_BEEF, 0, 0, 0, 32'h0000_8001, 0, 0, " abs short");
    run(4'd8, 2'd0, 32'hDEAD_BEEF, 0, 0, 0, 32'hCAFE_0000, 0, 0, " abs long");
    run(4'd9, 2'd0, 32'h0, 0, 0, 0, 32'h0000_FFFC, 0, 32'h0000_0002, " pc disp wrap R10");
    run(4'd10, 2'd0, 32'h0, 32'h0000_0003, 1, 2'd1, 32'h0000_7FFF, 2'd1, 32'h4000_0000, " pc idx");
    run(4'd13, 2'd1, 32'h7777_0000, 0, 0, 0, 32'h1, 0, 0, " reserved");
    idle_cycle();

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) idle_cycle();
      else run(4'($urandom_range(0, 15)), 2'($urandom), $urandom, $urandom, 1'($urandom),
               2'($urandom), $urandom, 2'($urandom), $urandom, " random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule